// File: doc/BRIEF.md
# Four-Mode Addressable Latch Bank

This block is a bank of level-sensitive storage bits that are written one at a time through a binary select address. It has a single serial data bit, an active-low write gate (`wr_gate_n`) and an active-low wipe input (`wipe_n`). These two controls pick one of four modes.

- **Addressable write:** the selected bit is written.
- **Demultiplexer:** the selected bit is written and every other bit is cleared.
- **Hold:** the bank is frozen.
- **Wipe:** every bit is cleared.

Each stored bit drives one output directly.

Typical uses are setting individual control lines from a narrow path (addressable write mode), or steering one data line to one of many destinations (demultiplexer mode). Every bit is a transparent latch. While the write gate is low, the selected bit follows the data input. When the gate rises, the values present at that moment are kept. The bank has no reset of its own. Its contents are undefined until the first wipe or write. The width is set by the address width; the output count is two to the power of that width.

Top module: `addr_latch_bank`

## Requirements
- R1: With `wipe_n` low and `wr_gate_n` high, every output bit is 0, whatever `sel` and `din` are.
- R2: With `wipe_n` high and `wr_gate_n` low, output `q[sel]` follows `din` transparently.
- R3: With `wipe_n` high and `wr_gate_n` low, every output other than `q[sel]` keeps its stored value.
- R4: With both `wipe_n` and `wr_gate_n` high, no output changes, and changes on `din` or `sel` have no effect.
- R5: When `wr_gate_n` rises, the `din` and `sel` present at that edge are the values stored, and they stay stored afterwards.
- R6: With both `wipe_n` and `wr_gate_n` low, `q[sel]` follows `din` and every other output is 0.
- R7: Demultiplexer mode clears the stored value of the unselected bits. After a switch to hold mode, those bits still read 0.
- R8: `sel` is an unsigned binary index with its MSB as the high-order bit. Value k selects `q[k]`, and `q[0]` is the LSB of the output vector.
- R9: If `sel` changes while writing in addressable mode, the previously selected output keeps the last `din` it saw while it was selected.
- R10: The output count `NUM_OUT` equals 2**`ADDR_W` (8 with the defaults), and elaboration rejects any other value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_gate_n | input | 1 | Active-low write gate; the rising edge closes the latches |
| wipe_n | input | 1 | Active-low wipe; selects demultiplexer mode or wipe mode together with the gate |
| sel | input | ADDR_W | Binary index of the bit to write |
| din | input | 1 | Data bit written to the selected output |
| q | output | NUM_OUT | Stored bits, one per index |

## Verification
The bench goes after transitions between modes, where a latch design goes wrong most easily.

- **Demultiplexer followed by hold.** It must show zeros in the unselected bits. A design that only masks the outputs in demultiplexer mode would bring old data back here.
- **Moving the address while writing in addressable mode.** A decoder that did not release the old index would overwrite the old bit.
- **Changing data and address right after the gate rises.** A design that stored on the wrong edge, or left the latch open, would take the late values.

A behavioural model of every stored bit is compared with all outputs after each stimulus step. The same model then runs through a long pseudo-random walk over all modes and addresses.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;

   typedef enum logic [1:0] {
      MD_DEMUX = 2'b00,   // gate low, wipe low
      MD_WRITE = 2'b01,   // gate low, wipe high
      MD_WIPE  = 2'b10,   // gate high, wipe low
      MD_HOLD  = 2'b11    // gate high, wipe high
   } bank_mode_e;

   localparam int unsigned ADDR_W_MAX = 10;

   function automatic bank_mode_e mode_of(input logic gate_n, input logic wipe_n);
      return bank_mode_e'({gate_n, wipe_n});
   endfunction

endpackage

// File: rtl/al_mode_decode.sv
module al_mode_decode
   import addr_latch_pkg::*;
(
   input  logic       gate_n,
   input  logic       wipe_n,
   output bank_mode_e mode,
   output logic       wr_open,
   output logic       clr_rest,
   output logic       clr_all
);
   always_comb begin
      mode     = mode_of(gate_n, wipe_n);
      wr_open  = 1'b0;
      clr_rest = 1'b0;
      clr_all  = 1'b0;
      unique case (mode)
         MD_DEMUX: begin
            wr_open  = 1'b1;
            clr_rest = 1'b1;
         end
         MD_WRITE: wr_open = 1'b1;
         MD_WIPE:  clr_all = 1'b1;
         MD_HOLD:  ;
         default:  ;
      endcase
   end
endmodule

// File: rtl/al_index_decode.sv
module al_index_decode #(
   parameter int unsigned ADDR_W    = 3,
   parameter int unsigned DEC_STYLE = 0,
   parameter int unsigned NUM_OUT   = 1 << ADDR_W
) (
   input  logic [ADDR_W-1:0]  idx,
   output logic [NUM_OUT-1:0] hot
);
   if (DEC_STYLE > 1) begin : g_bad_style
      $error("al_index_decode: DEC_STYLE must be 0 or 1");
   end

   if (DEC_STYLE == 0) begin : g_compare
      for (genvar k = 0; k < NUM_OUT; k++) begin : g_cmp
         assign hot[k] = (idx == ADDR_W'(k));
      end
   end else begin : g_shift
      assign hot = NUM_OUT'(1) << idx;
   end
endmodule

// File: rtl/al_store_cell.sv
module al_store_cell (
   input  logic picked,
   input  logic wr_open,
   input  logic clr_rest,
   input  logic clr_all,
   input  logic d_in,
   output logic q_out
);
   logic gate_on;
   logic next_val;

   assign gate_on  = clr_all | (wr_open & (picked | clr_rest));
   assign next_val = wr_open & picked & d_in;

   always_latch begin
      if (gate_on) q_out = next_val;
   end
endmodule

// File: rtl/addr_latch_bank.sv
module addr_latch_bank
   import addr_latch_pkg::*;
#(
   parameter int unsigned ADDR_W    = 3,
   parameter int unsigned DEC_STYLE = 0,
   parameter int unsigned NUM_OUT   = 1 << ADDR_W
) (
   input  logic               wr_gate_n,
   input  logic               wipe_n,
   input  logic [ADDR_W-1:0]  sel,
   input  logic               din,
   output logic [NUM_OUT-1:0] q
);
   if (ADDR_W < 1 || ADDR_W > ADDR_W_MAX) begin : g_bad_width
      $error("addr_latch_bank: ADDR_W out of range");
   end
   if (NUM_OUT != (1 << ADDR_W)) begin : g_bad_count
      $error("addr_latch_bank: NUM_OUT must be 2**ADDR_W");
   end

   bank_mode_e         mode;
   logic               wr_open;
   logic               clr_rest;
   logic               clr_all;
   logic [NUM_OUT-1:0] hot;

   al_mode_decode u_mode (
      .gate_n   (wr_gate_n),
      .wipe_n   (wipe_n),
      .mode     (mode),
      .wr_open  (wr_open),
      .clr_rest (clr_rest),
      .clr_all  (clr_all)
   );

   al_index_decode #(
      .ADDR_W    (ADDR_W),
      .DEC_STYLE (DEC_STYLE),
      .NUM_OUT   (NUM_OUT)
   ) u_dec (
      .idx (sel),
      .hot (hot)
   );

   for (genvar k = 0; k < NUM_OUT; k++) begin : g_cell
      al_store_cell u_cell (
         .picked   (hot[k]),
         .wr_open  (wr_open),
         .clr_rest (clr_rest),
         .clr_all  (clr_all),
         .d_in     (din),
         .q_out    (q[k])
      );
   end
endmodule

// File: rtl/addr_latch_bank_chk.sv
module addr_latch_bank_chk #(
   parameter int unsigned ADDR_W  = 3,
   parameter int unsigned NUM_OUT = 1 << ADDR_W
) (
   input logic               wr_gate_n,
   input logic               wipe_n,
   input logic [ADDR_W-1:0]  sel,
   input logic               din,
   input logic [NUM_OUT-1:0] q
);
   always_comb begin
      // R1
      if (wr_gate_n && !wipe_n) wipe_zero_chk: assert (q == '0);
      // R2
      if (!wr_gate_n) sel_follow_chk: assert (q[sel] == din);
      // R6
      if (!wr_gate_n && !wipe_n) demux_onehot_chk: assert ($countones(q) <= 1 && q[sel] == din);
   end

   // R4
   always @(q) begin
      hold_frozen_chk: assert (!(wr_gate_n && wipe_n));
   end
endmodule

bind addr_latch_bank addr_latch_bank_chk #(
   .ADDR_W  (ADDR_W),
   .NUM_OUT (NUM_OUT)
) u_chk (
   .wr_gate_n (wr_gate_n),
   .wipe_n    (wipe_n),
   .sel       (sel),
   .din       (din),
   .q         (q)
);

// File: tb/sim_addr_latch_bank.sv
module sim_addr_latch_bank;
   localparam int AW = 3;
   localparam int NO = 1 << AW;

   logic          clk = 1'b0;
   logic          wr_gate_n = 1'b1;
   logic          wipe_n = 1'b0;
   logic [AW-1:0] sel = '0;
   logic          din = 1'b0;
   logic [NO-1:0] q;

   int checks = 0;
   int failures = 0;
   int mdl[NO];
   bit done = 0;

   always #5 clk = ~clk;

   addr_latch_bank u0 (
      .wr_gate_n (wr_gate_n),
      .wipe_n    (wipe_n),
      .sel       (sel),
      .din       (din),
      .q         (q)
   );

   function automatic void rule(input logic g, input logic w, input int a, input logic d);
      if (!g) begin
         if (!w) for (int i = 0; i < NO; i++) mdl[i] = 0;
         mdl[a] = int'(d);
      end else if (!w) begin
         for (int i = 0; i < NO; i++) mdl[i] = 0;
      end
   endfunction

   function automatic logic [NO-1:0] expect_vec();
      logic [NO-1:0] v;
      for (int i = 0; i < NO; i++) v[i] = (mdl[i] != 0);
      return v;
   endfunction

   task automatic check(input string tag);
      logic [NO-1:0] e;
      e = expect_vec();
      checks++;
      if (q !== e) begin
         failures++;
         $display("FAIL %s q=%b expected=%b", tag, q, e);
      end
   endtask

   task automatic step(input logic g, input logic w, input int a, input logic d, input string tag);
      @(negedge clk);
      if (g && !wr_gate_n) begin
         wr_gate_n = g; wipe_n = w;
         rule(g, w, int'(sel), din);
         #1;
         sel = AW'(a); din = d;
         rule(g, w, a, d);
      end else begin
         sel = AW'(a); din = d;
         rule(wr_gate_n, wipe_n, a, d);
         #1;
         wr_gate_n = g; wipe_n = w;
         rule(g, w, a, d);
      end
      @(posedge clk); #1;
      check(tag);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int lfsr = 32'h1d3a;
      for (int i = 0; i < NO; i++) mdl[i] = 0;
      // Initial wipe: gives the bank a known state (R1)
      @(posedge clk); #1;
      check("R1 reset wipe");
      checks++;
      if ($bits(q) != 8) begin
         failures++;
         $display("FAIL R10 width=%0d expected=8", $bits(q));
      end

      // R2 R8: set each index in turn, then clear it again
      for (int a = 0; a < NO; a++) step(1'b0, 1'b1, a, 1'b1, "R2 R8 write one");
      step(1'b1, 1'b1, 0, 1'b0, "R5 hold after writes");
      for (int a = 0; a < NO; a += 2) step(1'b0, 1'b1, a, 1'b0, "R3 clear evens");

      // R4: hold mode with data and address moving
      for (int a = 0; a < NO; a++) step(1'b1, 1'b1, a, a[0], "R4 hold ignores");

      // R9: address moves while writing in addressable mode
      step(1'b0, 1'b1, 2, 1'b1, "R9 write idx2");
      step(1'b0, 1'b1, 5, 1'b0, "R9 move to idx5");
      step(1'b0, 1'b1, 6, 1'b1, "R9 move to idx6");

      // R5: gate rises, then data and address change
      step(1'b0, 1'b1, 4, 1'b1, "R5 pre-edge");
      step(1'b1, 1'b1, 4, 1'b0, "R5 after edge data change");
      step(1'b1, 1'b1, 0, 1'b0, "R5 after edge addr change");

      // R6 R8: demultiplexer at every index
      for (int a = 0; a < NO; a++) begin
         step(1'b0, 1'b0, a, 1'b1, "R6 R8 demux one");
         step(1'b0, 1'b0, a, 1'b0, "R6 demux zero");
      end

      // R7: fill, demux at idx3, then hold
      for (int a = 0; a < NO; a++) step(1'b0, 1'b1, a, 1'b1, "R3 fill");
      step(1'b0, 1'b0, 3, 1'b1, "R7 demux idx3");
      step(1'b1, 1'b1, 3, 1'b0, "R7 hold keeps zeros");
      step(1'b0, 1'b1, 7, 1'b1, "R7 write after demux");

      // R1: wipe mode with inputs moving
      for (int a = 0; a < NO; a++) step(1'b1, 1'b0, a, 1'b1, "R1 wipe ignores inputs");

      // Pseudo-random walk across all modes and transitions
      for (int n = 0; n < 600; n++) begin
         lfsr = (lfsr << 1) ^ (((lfsr >> 15) ^ (lfsr >> 13) ^ (lfsr >> 12) ^ (lfsr >> 10)) & 1);
         lfsr = lfsr & 32'hffff;
         step(lfsr[5], lfsr[7] | lfsr[9], lfsr[2:0], lfsr[11], "R2 R3 R4 R6 random");
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule